// File: doc/BRIEF.md
# CD Sector Decoder Host Register Port

This block is the byte-wide register front end that a host processor uses to steer a CD-ROM sector decoder. The host first loads a 5-bit address register, then reads or writes data bytes at that address. Each data read returns the selected register and steps the address register forward by one, modulo 32. A host can therefore sweep a run of registers with a single address load. Data writes do not move the address.

The block holds the interface control byte, the block pointer, two control bytes and an active-low interrupt status byte. It also counts command bytes received from the host. Certain writes fire one-cycle strobes to the neighbouring blocks: transfer start, transfer acknowledge, pointer load (decode start) and soft reset. The transfer engine and the decoding datapath report back on two pulse inputs, which pull the matching status flags low. A single interrupt line is raised while any enabled flag is low.

The host side is a plain synchronous strobe bus with no valid/ready pair. Every strobe is taken in the cycle it is high, so there is no back-pressure and the host never waits. Read data appears on `rdata` one cycle after the read strobe and holds until the next read.

Top module: `cdc_host_regs`

## Requirements
- R1: A strobe on `ar_wr` loads the address register with `wdata[4:0]`. Bits 7..5 are dropped. When `ar_wr` and `dat_rd` are high in the same cycle, the loaded value wins over the increment.
- R2: A strobe on `dat_rd` latches the register at the current address into `rdata` one cycle later. It then advances the address by one, wrapping from 31 to 0. Read map: 0 command count, 1 status, 2 interface control, 3 pointer low, 4 pointer high, 5 control 0, 6 control 1, 7..15 read 0x00.
- R3: A read at an address of 16 or more returns 0xFF and still advances the address.
- R4: Reset, and a data write at address 15, set the status byte to 0xFF and the command count to 0. The write at address 15 also pulses `soft_rst` for one cycle.
- R5: A data write at address 1 loads the interface control byte, shown on `if_ctl`. Bit 7 enables the command interrupt, bit 6 the transfer-end interrupt, bit 5 the decode interrupt, and bit 1 is data-output enable.
- R6: A data write at address 2 with `wdata[1]` = 1 clears status bit 3 (busy, active low) and pulses `xfer_start`. With `wdata[1]` = 0, the write does nothing.
- R7: A data write at address 3 sets status bit 6 (transfer end, active low) and pulses `xfer_ack`. A `xfer_done` pulse clears bit 6 and sets bit 3. When both arrive in the same cycle, the write wins for bit 6.
- R8: Data writes at 4 and 5 load the pointer low and high bytes, shown on `ptr`. A write at 5 pulses `ptr_load` and sets status bit 5 (decode, active low). A `dec_done` pulse clears bit 5.
- R9: A data write at address 0 increments the 8-bit command count and clears status bit 7. A data read at address 0 sets bit 7 again. A write wins over a read in the same cycle.
- R10: `irq` is high exactly when, for some bit n in {7,6,5}, `if_ctl[n]` is 1 and status bit n is 0.
- R11: Data writes at 6 and 7 load control bytes 0 and 1. These are shown on `ctl0` and `ctl1`.
- R12: Data writes at addresses 8..14 and 16..31 change no register and fire no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ar_wr | input | 1 | Address register write strobe |
| dat_wr | input | 1 | Data write strobe |
| dat_rd | input | 1 | Data read strobe |
| wdata | input | 8 | Write data for address and data writes |
| rdata | output | 8 | Read data, valid one cycle after `dat_rd` |
| xfer_done | input | 1 | Transfer engine finished pulse |
| dec_done | input | 1 | Decoder finished pulse |
| xfer_start | output | 1 | Transfer start strobe |
| xfer_ack | output | 1 | Transfer acknowledge strobe |
| ptr_load | output | 1 | Pointer load / decode start strobe |
| soft_rst | output | 1 | Soft reset strobe |
| ptr | output | 16 | Block pointer |
| if_ctl | output | 8 | Interface control byte |
| ctl0 | output | 8 | Control byte 0 |
| ctl1 | output | 8 | Control byte 1 |
| irq | output | 1 | Combined interrupt request |

## Verification
Every result is due one cycle after the clock edge that samples its strobe. This covers `rdata`, the address step, status changes, control bytes and the four strobes. `irq` follows the status and control registers with no further delay, so it is due in that same cycle. The bench drives inputs on the falling edge. It keeps a behavioural model that it advances on each rising edge, and it compares every output against that model at the next falling edge, which is exactly the cycle the design is due to respond. Directed reads of literal values add checks on the masking, out-of-range reads, wrap-around and same-cycle priorities.

// File: rtl/cdc_regs_pkg.sv
package cdc_regs_pkg;
  // data-write address map
  localparam int WA_CMD   = 0;
  localparam int WA_IFCTL = 1;
  localparam int WA_XGO   = 2;
  localparam int WA_XACK  = 3;
  localparam int WA_PLO   = 4;
  localparam int WA_PHI   = 5;
  localparam int WA_CTL0  = 6;
  localparam int WA_CTL1  = 7;
  // data-read address map
  localparam int RA_CNT   = 0;
  localparam int RA_STAT  = 1;
  localparam int RA_IFCTL = 2;
  localparam int RA_PLO   = 3;
  localparam int RA_PHI   = 4;
  localparam int RA_CTL0  = 5;
  localparam int RA_CTL1  = 6;
  // status bit positions (all active low)
  localparam int ST_CMD  = 7;
  localparam int ST_XEND = 6;
  localparam int ST_DEC  = 5;
  localparam int ST_BSY  = 3;
  // interface control bit positions
  localparam int IF_CMDIE = 7;
  localparam int IF_XEIE  = 6;
  localparam int IF_DECIE = 5;
  localparam int IF_DOUT  = 1;

  typedef struct packed {
    logic cmd;
    logic ifctl;
    logic xgo;
    logic xack;
    logic plo;
    logic phi;
    logic ctl0;
    logic ctl1;
    logic srst;
  } wr_hit_t;
endpackage

// File: rtl/cdc_addr_ptr.sv
module cdc_addr_ptr #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] ar
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ar <= '0;
    else if (load) ar <= load_val;
    else if (step) ar <= ar + 1'b1;
  end

  // R1
  ar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ar == $past(load_val));

  // R2
  ar_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> ar == AW'($past(ar) + 1'b1));
endmodule

// File: rtl/cdc_wr_decode.sv
module cdc_wr_decode
  import cdc_regs_pkg::*;
#(
  parameter int AW       = 5,
  parameter int NUM_REGS = 16
) (
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  output wr_hit_t       hit
);
  localparam int WA_SRST = NUM_REGS - 1;

  always_comb begin
    hit = '0;
    if (wr_en) begin
      case (int'(addr))
        WA_CMD:   hit.cmd   = 1'b1;
        WA_IFCTL: hit.ifctl = 1'b1;
        WA_XGO:   hit.xgo   = 1'b1;
        WA_XACK:  hit.xack  = 1'b1;
        WA_PLO:   hit.plo   = 1'b1;
        WA_PHI:   hit.phi   = 1'b1;
        WA_CTL0:  hit.ctl0  = 1'b1;
        WA_CTL1:  hit.ctl1  = 1'b1;
        WA_SRST:  hit.srst  = 1'b1;
        default:  hit       = '0;
      endcase
    end
  end
endmodule

// File: rtl/cdc_status_unit.sv
module cdc_status_unit
  import cdc_regs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_hit,
  input  logic          start_hit,
  input  logic          ack_hit,
  input  logic          phi_hit,
  input  logic          srst_hit,
  input  logic          cmd_read,
  input  logic          xfer_done,
  input  logic          dec_done,
  input  logic [2:0]    irq_en,
  output logic [DW-1:0] stat,
  output logic [DW-1:0] cmd_cnt,
  output logic          irq
);
  logic [DW-1:0] stat_nxt;

  always_comb begin
    stat_nxt = stat;
    if (xfer_done) begin
      stat_nxt[ST_XEND] = 1'b0;
      stat_nxt[ST_BSY]  = 1'b1;
    end
    if (dec_done)  stat_nxt[ST_DEC]  = 1'b0;
    if (cmd_read)  stat_nxt[ST_CMD]  = 1'b1;
    if (cmd_hit)   stat_nxt[ST_CMD]  = 1'b0;
    if (start_hit) stat_nxt[ST_BSY]  = 1'b0;
    if (ack_hit)   stat_nxt[ST_XEND] = 1'b1;
    if (phi_hit)   stat_nxt[ST_DEC]  = 1'b1;
    if (srst_hit)  stat_nxt = '1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat    <= '1;
      cmd_cnt <= '0;
    end else begin
      stat <= stat_nxt;
      if (srst_hit)     cmd_cnt <= '0;
      else if (cmd_hit) cmd_cnt <= cmd_cnt + 1'b1;
    end
  end

  // irq_en order: {cmd, transfer end, decode}
  assign irq = (irq_en[2] & ~stat[ST_CMD]) |
               (irq_en[1] & ~stat[ST_XEND]) |
               (irq_en[0] & ~stat[ST_DEC]);

  // R4
  srst_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hit |=> (stat == '1) && (cmd_cnt == '0));

  // R6
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_hit |=> !stat[ST_BSY]);

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_hit |=> stat[ST_XEND]);

  // R9
  cmd_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_hit |=> cmd_cnt == DW'($past(cmd_cnt) + 1'b1));

  // R8
  dec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_done && !phi_hit && !srst_hit) |=> !stat[ST_DEC]);
endmodule

// File: rtl/cdc_host_regs.sv
module cdc_host_regs
  import cdc_regs_pkg::*;
#(
  parameter int AW       = 5,
  parameter int DW       = 8,
  parameter int NUM_REGS = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ar_wr,
  input  logic          dat_wr,
  input  logic          dat_rd,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          xfer_done,
  input  logic          dec_done,
  output logic          xfer_start,
  output logic          xfer_ack,
  output logic          ptr_load,
  output logic          soft_rst,
  output logic [2*DW-1:0] ptr,
  output logic [DW-1:0] if_ctl,
  output logic [DW-1:0] ctl0,
  output logic [DW-1:0] ctl1,
  output logic          irq
);
  localparam int PW = 2 * DW;

  logic [AW-1:0] ar;
  wr_hit_t       hit;
  logic          start_fire;
  logic [DW-1:0] stat, cmd_cnt, rd_val;

  cdc_addr_ptr #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(ar_wr), .load_val(wdata[AW-1:0]),
    .step(dat_rd), .ar(ar)
  );

  cdc_wr_decode #(.AW(AW), .NUM_REGS(NUM_REGS)) u_dec (
    .wr_en(dat_wr), .addr(ar), .hit(hit)
  );

  assign start_fire = hit.xgo & wdata[IF_DOUT];

  cdc_status_unit #(.DW(DW)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .cmd_hit(hit.cmd), .start_hit(start_fire), .ack_hit(hit.xack),
    .phi_hit(hit.phi), .srst_hit(hit.srst),
    .cmd_read(dat_rd && int'(ar) == RA_CNT),
    .xfer_done(xfer_done), .dec_done(dec_done),
    .irq_en({if_ctl[IF_CMDIE], if_ctl[IF_XEIE], if_ctl[IF_DECIE]}),
    .stat(stat), .cmd_cnt(cmd_cnt), .irq(irq)
  );

  // control bytes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_ctl <= '0;
      ptr    <= '0;
      ctl0   <= '0;
      ctl1   <= '0;
    end else begin
      if (hit.ifctl) if_ctl       <= wdata;
      if (hit.plo)   ptr[DW-1:0]  <= wdata;
      if (hit.phi)   ptr[PW-1:DW] <= wdata;
      if (hit.ctl0)  ctl0         <= wdata;
      if (hit.ctl1)  ctl1         <= wdata;
    end
  end

  // one-cycle strobes to neighbours
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_start <= 1'b0;
      xfer_ack   <= 1'b0;
      ptr_load   <= 1'b0;
      soft_rst   <= 1'b0;
    end else begin
      xfer_start <= start_fire;
      xfer_ack   <= hit.xack;
      ptr_load   <= hit.phi;
      soft_rst   <= hit.srst;
    end
  end

  // read mux
  always_comb begin
    case (int'(ar))
      RA_CNT:   rd_val = cmd_cnt;
      RA_STAT:  rd_val = stat;
      RA_IFCTL: rd_val = if_ctl;
      RA_PLO:   rd_val = ptr[DW-1:0];
      RA_PHI:   rd_val = ptr[PW-1:DW];
      RA_CTL0:  rd_val = ctl0;
      RA_CTL1:  rd_val = ctl1;
      default:  rd_val = (int'(ar) < NUM_REGS) ? '0 : '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (dat_rd) rdata <= rd_val;
  end

  // R12
  quiet_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> !xfer_start && !xfer_ack && !ptr_load && !soft_rst);

  // R11
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_wr |=> $stable(ctl0) && $stable(ctl1) && $stable(ptr) && $stable(if_ctl));
endmodule

// File: tb/test_cdc_host_regs.sv
module test_cdc_host_regs;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ar_wr = 0, dat_wr = 0, dat_rd = 0, xfer_done = 0, dec_done = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata, if_ctl, ctl0, ctl1;
  logic [15:0] ptr;
  logic xfer_start, xfer_ack, ptr_load, soft_rst, irq;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cdc_host_regs i_cdc_host_regs (
    .clk(clk), .rst_n(rst_n), .ar_wr(ar_wr), .dat_wr(dat_wr), .dat_rd(dat_rd),
    .wdata(wdata), .rdata(rdata), .xfer_done(xfer_done), .dec_done(dec_done),
    .xfer_start(xfer_start), .xfer_ack(xfer_ack), .ptr_load(ptr_load),
    .soft_rst(soft_rst), .ptr(ptr), .if_ctl(if_ctl), .ctl0(ctl0), .ctl1(ctl1),
    .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  logic [4:0]  m_ar;
  logic [7:0]  m_stat, m_cnt, m_ifc, m_plo, m_phi, m_c0, m_c1, m_rdata;
  logic        m_start, m_ack, m_load, m_rst;

  function automatic logic [7:0] m_read(input logic [4:0] a);
    case (a)
      0: return m_cnt;
      1: return m_stat;
      2: return m_ifc;
      3: return m_plo;
      4: return m_phi;
      5: return m_c0;
      6: return m_c1;
      default: return (a < 16) ? 8'h00 : 8'hFF;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ar = 0; m_stat = 8'hFF; m_cnt = 0; m_ifc = 0; m_plo = 0; m_phi = 0;
      m_c0 = 0; m_c1 = 0; m_rdata = 0;
      m_start = 0; m_ack = 0; m_load = 0; m_rst = 0;
    end else begin
      logic [7:0] rv, ns;
      rv = m_read(m_ar);
      ns = m_stat;
      m_start = 0; m_ack = 0; m_load = 0; m_rst = 0;
      if (xfer_done) begin ns[6] = 0; ns[3] = 1; end
      if (dec_done) ns[5] = 0;
      if (dat_rd && m_ar == 0) ns[7] = 1;
      if (dat_wr) begin
        case (m_ar)
          0: begin ns[7] = 0; m_cnt = m_cnt + 1; end
          1: m_ifc = wdata;
          2: if (wdata[1]) begin ns[3] = 0; m_start = 1; end
          3: begin ns[6] = 1; m_ack = 1; end
          4: m_plo = wdata;
          5: begin m_phi = wdata; ns[5] = 1; m_load = 1; end
          6: m_c0 = wdata;
          7: m_c1 = wdata;
          15: begin ns = 8'hFF; m_cnt = 0; m_rst = 1; end
          default: ;
        endcase
      end
      m_stat = ns;
      if (dat_rd) begin m_rdata = rv; m_ar = m_ar + 1; end
      if (ar_wr) m_ar = wdata[4:0];
    end
  end

  function automatic logic m_irq();
    return (m_ifc[7] & ~m_stat[7]) | (m_ifc[6] & ~m_stat[6]) | (m_ifc[5] & ~m_stat[5]);
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare on every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R2 rdata vs model", {8'h0, rdata}, {8'h0, m_rdata});
      check("R10 irq vs model", {15'h0, irq}, {15'h0, m_irq()});
      check("R6 xfer_start vs model", {15'h0, xfer_start}, {15'h0, m_start});
      check("R7 xfer_ack vs model", {15'h0, xfer_ack}, {15'h0, m_ack});
      check("R8 ptr_load vs model", {15'h0, ptr_load}, {15'h0, m_load});
      check("R4 soft_rst vs model", {15'h0, soft_rst}, {15'h0, m_rst});
      check("R8 ptr vs model", ptr, {m_phi, m_plo});
      check("R5 if_ctl vs model", {8'h0, if_ctl}, {8'h0, m_ifc});
      check("R11 ctl vs model", {ctl1, ctl0}, {m_c1, m_c0});
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic set_ar(input logic [7:0] v);
    @(negedge clk); ar_wr = 1; wdata = v;
    @(negedge clk); ar_wr = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); dat_wr = 1; wdata = v;
    @(negedge clk); dat_wr = 0;
  endtask

  task automatic rd(output logic [7:0] v);
    @(negedge clk); dat_rd = 1;
    @(negedge clk); dat_rd = 0; v = rdata;
  endtask

  task automatic wr_at(input logic [7:0] a, input logic [7:0] v);
    set_ar(a); wr(v);
  endtask

  task automatic rd_at(input logic [7:0] a, output logic [7:0] v);
    set_ar(a); rd(v);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state
    check("R4 irq after reset", {15'h0, irq}, 16'h0);
    rd_at(8'h01, v); check("R4 status after reset", {8'h0, v}, 16'h00FF);
    rd(v);           check("R2 auto-increment to if_ctl", {8'h0, v}, 16'h0000);
    // R1 masking
    rd_at(8'h21, v); check("R1 masked address", {8'h0, v}, 16'h00FF);
    // R3 out of range and wrap
    rd_at(8'd20, v); check("R3 out of range read", {8'h0, v}, 16'h00FF);
    rd_at(8'd31, v); check("R3 top address read", {8'h0, v}, 16'h00FF);
    rd(v);           check("R2 wrap to address 0", {8'h0, v}, 16'h0000);
    rd_at(8'd9, v);  check("R2 unassigned reads zero", {8'h0, v}, 16'h0000);
    // R5 control byte
    wr_at(8'd1, 8'hE2);
    rd_at(8'd2, v); check("R5 if_ctl readback", {8'h0, v}, 16'h00E2);
    // R9 command write / read
    wr_at(8'd0, 8'h55);
    check("R9 R10 irq on command", {15'h0, irq}, 16'h1);
    rd_at(8'd0, v); check("R9 command count", {8'h0, v}, 16'h0001);
    check("R9 read releases command flag", {15'h0, irq}, 16'h0);
    // R6 trigger
    wr_at(8'd2, 8'h00);
    check("R6 no start without enable bit", {15'h0, xfer_start}, 16'h0);
    rd_at(8'd1, v); check("R6 busy unchanged", {8'h0, v}, 16'h00FF);
    wr_at(8'd2, 8'h02);
    check("R6 start strobe", {15'h0, xfer_start}, 16'h1);
    rd_at(8'd1, v); check("R6 busy low", {8'h0, v}, 16'h00F7);
    // R7 done and ack
    @(negedge clk); xfer_done = 1; @(negedge clk); xfer_done = 0;
    check("R7 R10 irq on transfer end", {15'h0, irq}, 16'h1);
    rd_at(8'd1, v); check("R7 status after done", {8'h0, v}, 16'h00BF);
    wr_at(8'd3, 8'h00);
    check("R7 ack strobe", {15'h0, xfer_ack}, 16'h1);
    check("R7 irq released by ack", {15'h0, irq}, 16'h0);
    // same-cycle done and ack: ack wins
    set_ar(8'd3);
    @(negedge clk); dat_wr = 1; xfer_done = 1;
    @(negedge clk); dat_wr = 0; xfer_done = 0;
    rd_at(8'd1, v); check("R7 ack wins over done", {8'h0, v}, 16'h00FF);
    // R8 pointer
    wr_at(8'd4, 8'h34);
    wr_at(8'd5, 8'h12);
    check("R8 pointer load strobe", {15'h0, ptr_load}, 16'h1);
    check("R8 pointer value", ptr, 16'h1234);
    @(negedge clk); dec_done = 1; @(negedge clk); dec_done = 0;
    check("R8 R10 irq on decode", {15'h0, irq}, 16'h1);
    rd_at(8'd3, v); check("R8 pointer low readback", {8'h0, v}, 16'h0034);
    rd(v);          check("R8 pointer high readback", {8'h0, v}, 16'h0012);
    // R11 controls
    wr_at(8'd6, 8'hA5);
    wr_at(8'd7, 8'h5A);
    check("R11 ctl outputs", {ctl1, ctl0}, 16'h5AA5);
    rd_at(8'd5, v); check("R11 ctl0 readback", {8'h0, v}, 16'h00A5);
    // R12 ignored writes
    wr_at(8'd9, 8'hFF);
    wr_at(8'd20, 8'hFF);
    check("R12 ctl unchanged", {ctl1, ctl0}, 16'h5AA5);
    check("R12 pointer unchanged", ptr, 16'h1234);
    rd_at(8'd1, v); check("R12 status unchanged", {8'h0, v}, 16'h00DF);
    // R4 soft reset
    wr_at(8'd0, 8'h01);
    wr_at(8'd15, 8'h00);
    check("R4 soft reset strobe", {15'h0, soft_rst}, 16'h1);
    rd_at(8'd1, v); check("R4 status after soft reset", {8'h0, v}, 16'h00FF);
    rd_at(8'd0, v); check("R4 count after soft reset", {8'h0, v}, 16'h0000);
    // R1 load wins over increment
    set_ar(8'd4);
    @(negedge clk); dat_rd = 1; ar_wr = 1; wdata = 8'd6;
    @(negedge clk); dat_rd = 0; ar_wr = 0;
    rd(v); check("R1 load beats increment", {8'h0, v}, 16'h005A);
    // random traffic against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      ar_wr     = ($urandom % 4) == 0;
      dat_wr    = ($urandom % 3) == 0;
      dat_rd    = ($urandom % 3) == 0;
      xfer_done = ($urandom % 8) == 0;
      dec_done  = ($urandom % 8) == 0;
      wdata     = 8'($urandom);
    end
    @(negedge clk);
    ar_wr = 0; dat_wr = 0; dat_rd = 0; xfer_done = 0; dec_done = 0;
    repeat (2) @(negedge clk);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule